// File: doc/BRIEF.md
# Radio Interrupt Controller with Polling Mode

This block gathers single-cycle event pulses from a radio core into an eight-bit status register and drives one external interrupt pin from it. Software sets an enable mask and a small configuration register. A pin-level bit selects active-high or active-low signalling. A latch-all bit lets events that are disabled in the mask still be recorded, so software can poll them without taking an interrupt.

Reading the status register returns its contents and clears every bit at the next clock edge. An event that arrives in the same cycle as that read is kept. One status bit is shared by two sources: wake-up completion and the end of a manually started energy-detect measurement. A separate override input from the frame-buffer logic can take over the pin. While the override is active, the pin shows the buffer-empty level, which is always active high.

The register port is a plain synchronous port with address, read strobe, write strobe and write data. Read data is combinational from the address. Address 0 is status, which is read-only and cleared by a read. Address 1 is the mask. Address 2 is the configuration: bit 0 selects an active-low pin, bit 1 enables latch-all, and the upper bits read as zero. The asynchronous active-low reset is released synchronously, two clock edges after it is deasserted.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset the status, mask and configuration registers all read 0x00, and the pin is low.
- R2: A pulse on evt_in[i] that is allowed to latch sets status bit i one cycle later. The bit assignments are: 0 PLL lock, 1 PLL unlock, 2 RX start, 3 TRX end, 4 awake or ED end, 5 address match, 6 TX underrun, 7 low battery.
- R3: Status bit 4 is set by either evt_in[4] (wake complete) or ed_done (energy-detect end).
- R4: With configuration bit 1 = 0, an event whose mask bit is 0 is not recorded in status.
- R5: With configuration bit 1 = 1, every event is recorded whatever the mask says. A recorded event whose mask bit is 0 does not assert the pin.
- R6: Without override, the pin is at its active level exactly while (status AND mask) is nonzero.
- R7: Configuration bit 0 = 1 inverts the pin, making it active low. Its idle level is then high.
- R8: A read strobe at address 0 returns the current status and clears all status bits at that clock edge.
- R9: An event in the same cycle as a clearing read is present in status afterwards.
- R10: While fbe_ovr is 1, the pin equals fbe_empty regardless of the polarity bit.
- R11: Status bits stay set until a clearing read. Reads at other addresses and writes to address 0 do not change status.
- R12: The mask and configuration registers read back what was written. Configuration bits 7:2 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Single-cycle event pulses, one per status bit |
| ed_done | input | 1 | Energy-detect end pulse, shares status bit 4 |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| fbe_ovr | input | 1 | Frame-buffer-empty override active |
| fbe_empty | input | 1 | Frame-buffer-empty level, active high |
| irq_pin | output | 1 | Interrupt pin |

## Verification
On every cycle, the assertions check the following:
- the override level on the pin;
- the idle pin level set by the polarity bit;
- that status bits are sticky between reads;
- that a clearing read with no event empties status;
- that a clearing read keeps only the events of that same cycle;
- that disabled events are dropped while latch-all is off.

The bench sweeps both configuration bits, every event bit and several mask patterns, and computes the expected status and pin level arithmetically. It also covers all 256 event patterns against a fixed mask. Only these scenarios can show the following:
- the reset values;
- the exact bit mapping and the shared bit 4;
- register readback;
- that writes to status and reads of other addresses have no effect.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CFG    = 2'd2;
  localparam int unsigned CFG_W = 2;

  typedef struct packed {
    logic latch_all;  // bit 1
    logic pol_low;    // bit 0
  } irq_cfg_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_evt_merge.sv
module irq_evt_merge #(
  parameter int unsigned NUM_EVT    = 8,
  parameter int unsigned SHARED_IDX = 4
) (
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               ed_done,
  output logic [NUM_EVT-1:0] evt_vec
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    if (i == SHARED_IDX) begin : g_shared
      assign evt_vec[i] = evt_in[i] | ed_done;
    end else begin : g_plain
      assign evt_vec[i] = evt_in[i];
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import radio_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic               wr_cfg,
  input  logic [NUM_EVT-1:0] wdata,
  output logic [NUM_EVT-1:0] mask,
  output irq_cfg_t           cfg
);
  logic [NUM_EVT-1:0] mask_d;
  irq_cfg_t           cfg_d;

  always_comb begin
    mask_d = mask;
    cfg_d  = cfg;
    if (wr_mask) mask_d = wdata;
    if (wr_cfg)  cfg_d  = irq_cfg_t'(wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      cfg  <= '0;
    end else begin
      if (wr_mask) mask <= mask_d;
      if (wr_cfg)  cfg  <= cfg_d;
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] mask,
  input  logic               latch_all,
  input  logic               rd_clr,
  output logic [NUM_EVT-1:0] status
);
  logic [NUM_EVT-1:0] allow;
  logic [NUM_EVT-1:0] status_d;

  always_comb begin
    allow    = latch_all ? {NUM_EVT{1'b1}} : mask;
    status_d = (rd_clr ? '0 : status) | (evt & allow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  // R11: bits stay set without a clearing read
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((status & $past(status)) == $past(status)));
  // R8: a clearing read with no event empties status
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == '0) |=> (status == '0));
  // R9: after a clearing read only that cycle's events remain
  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((status & ~$past(evt)) == '0));
  // R4: disabled events are dropped while latch-all is off
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_all |=> ((status & ~$past(status) & ~$past(mask)) == '0));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0] status,
  input  logic [NUM_EVT-1:0] mask,
  input  logic               pol_low,
  input  logic               ovr,
  input  logic               ovr_level,
  output logic               pin
);
  logic pending;
  always_comb begin
    pending = |(status & mask);
    pin     = ovr ? ovr_level : (pending ^ pol_low);
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import radio_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT    = 8,
  parameter int unsigned SHARED_IDX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               ed_done,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NUM_EVT-1:0] reg_rdata,
  input  logic               fbe_ovr,
  input  logic               fbe_empty,
  output logic               irq_pin
);
  localparam int unsigned PAD_W = NUM_EVT - CFG_W;

  logic               rst_i_n;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] mask;
  logic [NUM_EVT-1:0] status;
  irq_cfg_t           cfg;
  logic               rd_clr, wr_mask, wr_cfg;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  irq_evt_merge #(.NUM_EVT(NUM_EVT), .SHARED_IDX(SHARED_IDX)) u_merge (
    .evt_in(evt_in), .ed_done(ed_done), .evt_vec(evt_vec));

  always_comb begin
    rd_clr  = reg_rd && (reg_addr == ADDR_STATUS);
    wr_mask = reg_wr && (reg_addr == ADDR_MASK);
    wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
    case (reg_addr)
      ADDR_STATUS: reg_rdata = status;
      ADDR_MASK:   reg_rdata = mask;
      ADDR_CFG:    reg_rdata = {{PAD_W{1'b0}}, cfg};
      default:     reg_rdata = '0;
    endcase
  end

  irq_cfg_regs #(.NUM_EVT(NUM_EVT)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_mask(wr_mask), .wr_cfg(wr_cfg),
    .wdata(reg_wdata), .mask(mask), .cfg(cfg));

  irq_status_reg #(.NUM_EVT(NUM_EVT)) u_status (
    .clk(clk), .rst_n(rst_i_n), .evt(evt_vec), .mask(mask),
    .latch_all(cfg.latch_all), .rd_clr(rd_clr), .status(status));

  irq_pin_drive #(.NUM_EVT(NUM_EVT)) u_pin (
    .status(status), .mask(mask), .pol_low(cfg.pol_low),
    .ovr(fbe_ovr), .ovr_level(fbe_empty), .pin(irq_pin));

  // R10: override level ignores polarity
  assert_ovr_level_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    fbe_ovr |-> (irq_pin == fbe_empty));
  // R7: with nothing pending the pin rests at the polarity bit's level
  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!fbe_ovr && ((status & mask) == '0)) |-> (irq_pin == cfg.pol_low));
endmodule

// File: tb/tb_radio_irq_ctrl.sv
module tb_radio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_in;
  logic       ed_done;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       fbe_ovr, fbe_empty;
  logic       irq_pin;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  radio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ed_done(ed_done),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fbe_ovr(fbe_ovr), .fbe_empty(fbe_empty), .irq_pin(irq_pin));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  // reads the register; a status read also clears it
  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [7:0] ev, logic ed);
    evt_in = ev; ed_done = ed;
    cyc();
    evt_in = '0; ed_done = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] masks [4];
    rst_n = 1'b0; evt_in = '0; ed_done = 1'b0; reg_addr = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    fbe_ovr = 1'b0; fbe_empty = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    reg_addr = 2'd1; #1 chk("R1 mask reset", reg_rdata, 8'h00);
    reg_addr = 2'd2; #1 chk("R1 cfg reset", reg_rdata, 8'h00);
    reg_addr = 2'd0; #1 chk("R1 status reset", reg_rdata, 8'h00);
    chk("R1 pin reset", {7'd0, irq_pin}, 8'h00);
    cyc();

    // R12 readback
    wr(2'd1, 8'h5A); rd(2'd1, d); chk("R12 mask readback", d, 8'h5A);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R12 cfg readback", d, 8'h03);
    wr(2'd2, 8'h00);

    // R2 R4 R5 R6 R7 R8 sweep
    for (int mm = 0; mm < 2; mm++) begin
      for (int pl = 0; pl < 2; pl++) begin
        wr(2'd2, 8'(mm * 2 + pl));
        for (int b = 0; b < 8; b++) begin
          masks[0] = 8'h00; masks[1] = 8'hFF;
          masks[2] = 8'(1 << b); masks[3] = ~8'(1 << b);
          for (int m = 0; m < 4; m++) begin
            logic [7:0] exp_st;
            logic       exp_pin;
            wr(2'd1, masks[m]);
            pulse(8'(1 << b), 1'b0);
            exp_st  = (mm == 1 || masks[m][b]) ? 8'(1 << b) : 8'h00;
            exp_pin = ((exp_st & masks[m]) != 0) ^ pl[0];
            chk("R6 R7 pin level", {7'd0, irq_pin}, {7'd0, exp_pin});
            rd(2'd0, d);
            chk(mm ? "R5 R2 status latch-all" : "R4 R2 status masked", d, exp_st);
            rd(2'd0, d);
            chk("R8 cleared after read", d, 8'h00);
            chk("R7 idle pin", {7'd0, irq_pin}, {7'd0, pl[0]});
          end
        end
      end
    end

    // R4 all 256 patterns against a fixed mask
    wr(2'd2, 8'h00); wr(2'd1, 8'hA5);
    for (int v = 0; v < 256; v++) begin
      pulse(8'(v), 1'b0);
      rd(2'd0, d);
      chk("R4 pattern sweep", d, 8'(v) & 8'hA5);
    end

    // R3 shared bit
    wr(2'd1, 8'h10);
    pulse(8'h00, 1'b1); rd(2'd0, d); chk("R3 ed_done sets bit4", d, 8'h10);
    pulse(8'h10, 1'b0); rd(2'd0, d); chk("R3 wake sets bit4", d, 8'h10);

    // R9 event in the same cycle as a clearing read
    wr(2'd1, 8'hFF);
    pulse(8'h01, 1'b0);
    evt_in = 8'h08;
    rd(2'd0, d);
    evt_in = 8'h00;
    chk("R9 read returns old status", d, 8'h01);
    rd(2'd0, d); chk("R9 same-cycle event kept", d, 8'h08);

    // R11 sticky, other reads and status writes have no effect
    pulse(8'h81, 1'b0);
    pulse(8'h00, 1'b0);
    rd(2'd1, d);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R11 status sticky", d, 8'h81);

    // R10 override
    for (int pl = 0; pl < 2; pl++) begin
      wr(2'd2, 8'(pl));
      pulse(8'h04, 1'b0);
      fbe_ovr = 1'b1;
      fbe_empty = 1'b0; #1 chk("R10 override low", {7'd0, irq_pin}, 8'h00);
      fbe_empty = 1'b1; #1 chk("R10 override high", {7'd0, irq_pin}, 8'h01);
      cyc();
      fbe_ovr = 1'b0; fbe_empty = 1'b0;
      #1 chk("R6 pin after override", {7'd0, irq_pin}, 8'(1 - pl));
      rd(2'd0, d);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule